// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table that lives in memory. A translation request carries the virtual address, a write flag and a user-mode flag. The walker splits the address into a directory index, a table index and a page offset. It fetches the directory entry from the page whose frame number sits in a root register, then fetches the second-level entry. The result is either a physical address or a fault.

Each entry carries a frame number in its upper 20 bits and flags in its low 12 bits. The walker checks the presence, write and user flags at both levels. On success it sets the accessed flag, and on writes the dirty flag, by writing the changed entry back to memory. It issues that write-back only when a flag actually changes. On a fault the offending virtual address is latched into a fault-address output.

Only one translation is in flight. Requests and responses use a valid/ready handshake. The memory side is a single-outstanding port. A read is answered by a one-cycle `mem_rsp_valid` pulse some cycles after acceptance. A write is complete when it is accepted and produces no response pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and `fault_vaddr` is 0.
- R2: The first read of a walk is at `{root_frame, 12'b0} + vaddr[31:22]*4`. The second read is at `{directory entry[31:12], 12'b0} + vaddr[21:12]*4`.
- R3: A successful translation returns `rsp_fault`=0 and `rsp_paddr` = `{leaf entry[31:12], vaddr[11:0]}`. Entry bits 3, 4 and 7 to 11 have no effect.
- R4: A directory entry with bit 0 (present) clear gives a fault after exactly one memory read and no memory write.
- R5: A second-level entry with bit 0 (present) clear gives a fault.
- R6: A write request faults when bit 1 (writable) is clear in either entry, in both user and kernel mode.
- R7: A user-mode request faults when bit 2 (user) is clear in either entry. A kernel-mode request ignores bit 2.
- R8: On success, bit 5 (accessed) is set in memory in both entries. On a write, bit 6 (dirty) is set in the second-level entry. All other bits are left unchanged.
- R9: An entry is written back only if a flag in it changes. The number of memory writes per walk equals the number of entries that change.
- R10: A fault latches the request's virtual address into `fault_vaddr`, which otherwise holds its value. A faulting entry is not written. A directory entry that passed its checks is still marked accessed.
- R11: `req_ready` is low from request acceptance until the response is taken. The response holds its values while `rsp_ready` is low.
- R12: All write-backs are accepted before `rsp_valid` rises, and no memory request is made while a response is pending or afterwards until a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_frame | input | 20 | Frame number of the directory page, sampled at acceptance |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result taken |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Translation faulted |
| fault_vaddr | output | 32 | Virtual address of the latest fault |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The first memory read appears the cycle after a request is accepted. Each later memory request follows one cycle after the previous read pulse or write acceptance. The response rises one cycle after the final read pulse or write-back acceptance. Because the bench's memory model stalls acceptance and varies read latency at random, the bench does not count to a fixed cycle. It handles every handshake at the falling edge, where both sides of the coming rising edge are already settled. It polls at falling edges for `rsp_valid` and samples the result and the memory image in the same half-cycle it raises `rsp_ready`. Fault-address and idle-traffic checks come one falling edge after the response is taken, when the register update has landed.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Flag positions inside a page table entry
    localparam int FLG_PRES  = 0;
    localparam int FLG_WR    = 1;
    localparam int FLG_USR   = 2;
    localparam int FLG_ACC   = 5;
    localparam int FLG_DIRTY = 6;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DIR_RD,
        WS_DIR_WAIT,
        WS_DIR_WB,
        WS_TBL_RD,
        WS_TBL_WAIT,
        WS_TBL_WB,
        WS_RESP
    } walk_state_e;

endpackage

// File: rtl/pt_index_split.sv
module pt_index_split #(
    parameter int ADDR_W   = 32,
    parameter int DIR_BITS = 10,
    parameter int TBL_BITS = 10,
    parameter int OFF_BITS = 12
) (
    input  logic [ADDR_W-1:0]          vaddr,
    input  logic [ADDR_W-OFF_BITS-1:0] dir_frame,
    input  logic [ADDR_W-OFF_BITS-1:0] tbl_frame,
    output logic [ADDR_W-1:0]          dir_ent_addr,
    output logic [ADDR_W-1:0]          tbl_ent_addr,
    output logic [OFF_BITS-1:0]        page_off
);
    localparam int ENT_SH = $clog2(ADDR_W / 8);

    logic [DIR_BITS-1:0] dir_idx;
    logic [TBL_BITS-1:0] tbl_idx;

    assign dir_idx  = vaddr[ADDR_W-1 -: DIR_BITS];
    assign tbl_idx  = vaddr[OFF_BITS +: TBL_BITS];
    assign page_off = vaddr[OFF_BITS-1:0];

    // entry address = page base + index * entry size
    assign dir_ent_addr = {dir_frame, {OFF_BITS{1'b0}}} | (ADDR_W'(dir_idx) << ENT_SH);
    assign tbl_ent_addr = {tbl_frame, {OFF_BITS{1'b0}}} | (ADDR_W'(tbl_idx) << ENT_SH);
endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
    import pt_walker_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic             is_user,
    input  logic             is_leaf,
    output logic             deny,
    output logic             need_wb,
    output logic [ENT_W-1:0] entry_upd
);
    always_comb begin
        deny = !entry[FLG_PRES]
            || (is_write && !entry[FLG_WR])
            || (is_user  && !entry[FLG_USR]);
        entry_upd = entry;
        entry_upd[FLG_ACC] = 1'b1;
        if (is_leaf && is_write) begin
            entry_upd[FLG_DIRTY] = 1'b1;
        end
        need_wb = (entry_upd != entry);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DIR_BITS = 10,
    parameter int TBL_BITS = 10,
    parameter int OFF_BITS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic                       req_write,
    input  logic                       req_user,
    input  logic [ADDR_W-OFF_BITS-1:0] root_frame,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic [ADDR_W-1:0]          rsp_paddr,
    output logic                       rsp_fault,
    output logic [ADDR_W-1:0]          fault_vaddr,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic                       mem_req_we,
    output logic [ADDR_W-1:0]          mem_req_addr,
    output logic [ADDR_W-1:0]          mem_req_wdata,
    input  logic                       mem_rsp_valid,
    input  logic [ADDR_W-1:0]          mem_rsp_rdata
);
    localparam int FRAME_W = ADDR_W - OFF_BITS;

    typedef struct packed {
        walk_state_e        st;
        logic [ADDR_W-1:0]  va;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] root;
        logic [ADDR_W-1:0]  pde;
        logic [ADDR_W-1:0]  pte;
        logic [ADDR_W-1:0]  pa;
        logic               flt;
        logic [ADDR_W-1:0]  fva;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [ADDR_W-1:0]   dir_addr, tbl_addr;
    logic [OFF_BITS-1:0] page_off;
    logic                ev_deny, ev_need_wb;
    logic [ADDR_W-1:0]   ev_upd;

    pt_index_split #(
        .ADDR_W  (ADDR_W),
        .DIR_BITS(DIR_BITS),
        .TBL_BITS(TBL_BITS),
        .OFF_BITS(OFF_BITS)
    ) i_split (
        .vaddr       (r_q.va),
        .dir_frame   (r_q.root),
        .tbl_frame   (r_q.pde[ADDR_W-1:OFF_BITS]),
        .dir_ent_addr(dir_addr),
        .tbl_ent_addr(tbl_addr),
        .page_off    (page_off)
    );

    pt_entry_eval #(
        .ENT_W(ADDR_W)
    ) i_eval (
        .entry    (mem_rsp_rdata),
        .is_write (r_q.wr),
        .is_user  (r_q.usr),
        .is_leaf  (r_q.st == WS_TBL_WAIT),
        .deny     (ev_deny),
        .need_wb  (ev_need_wb),
        .entry_upd(ev_upd)
    );

    // outputs decoded from the registered state
    always_comb begin
        req_ready     = (r_q.st == WS_IDLE);
        rsp_valid     = (r_q.st == WS_RESP);
        rsp_paddr     = r_q.pa;
        rsp_fault     = r_q.flt;
        fault_vaddr   = r_q.fva;
        mem_req_valid = (r_q.st == WS_DIR_RD) || (r_q.st == WS_DIR_WB)
                     || (r_q.st == WS_TBL_RD) || (r_q.st == WS_TBL_WB);
        mem_req_we    = (r_q.st == WS_DIR_WB) || (r_q.st == WS_TBL_WB);
        mem_req_addr  = ((r_q.st == WS_DIR_RD) || (r_q.st == WS_DIR_WB)) ? dir_addr : tbl_addr;
        mem_req_wdata = (r_q.st == WS_DIR_WB) ? r_q.pde : r_q.pte;
    end

    // next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    r_d.va   = req_vaddr;
                    r_d.wr   = req_write;
                    r_d.usr  = req_user;
                    r_d.root = root_frame;
                    r_d.st   = WS_DIR_RD;
                end
            end
            WS_DIR_RD: begin
                if (mem_req_ready) r_d.st = WS_DIR_WAIT;
            end
            WS_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ev_deny) begin
                        r_d.flt = 1'b1;
                        r_d.pa  = '0;
                        r_d.fva = r_q.va;
                        r_d.st  = WS_RESP;
                    end else begin
                        r_d.pde = ev_upd;
                        r_d.st  = ev_need_wb ? WS_DIR_WB : WS_TBL_RD;
                    end
                end
            end
            WS_DIR_WB: begin
                if (mem_req_ready) r_d.st = WS_TBL_RD;
            end
            WS_TBL_RD: begin
                if (mem_req_ready) r_d.st = WS_TBL_WAIT;
            end
            WS_TBL_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ev_deny) begin
                        r_d.flt = 1'b1;
                        r_d.pa  = '0;
                        r_d.fva = r_q.va;
                        r_d.st  = WS_RESP;
                    end else begin
                        r_d.flt = 1'b0;
                        r_d.pte = ev_upd;
                        r_d.pa  = {mem_rsp_rdata[ADDR_W-1:OFF_BITS], page_off};
                        r_d.st  = ev_need_wb ? WS_TBL_WB : WS_RESP;
                    end
                end
            end
            WS_TBL_WB: begin
                if (mem_req_ready) r_d.st = WS_RESP;
            end
            WS_RESP: begin
                if (rsp_ready) r_d.st = WS_IDLE;
            end
            default: r_d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic              rsp_fault,
    input logic [ADDR_W-1:0] fault_vaddr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [ADDR_W-1:0] mem_req_wdata
);
    // walk starts with a read one cycle after acceptance
    assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_req_valid && !mem_req_we));

    // memory request is held until accepted
    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

    // every write-back carries the accessed flag
    assert_wb_accessed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[FLG_ACC]);

    // fault address only moves when a response is issued
    assert_faddr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rsp_valid) |-> $stable(fault_vaddr));

    assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    assert_quiet_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req_valid);

    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .fault_vaddr  (fault_vaddr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] root_frame = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [31:0] fault_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;

    always #4 clk = ~clk;   // 125 MHz

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .root_frame(root_frame),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .fault_vaddr(fault_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] pmem [int unsigned];
    int          n_rd, n_wr;
    logic [31:0] rd_log [4];
    bit          rd_pend = 1'b0;
    int          rd_lat;
    logic [31:0] rd_data;
    logic [31:0] exp_fva = '0;

    function automatic logic [31:0] rd_word(logic [31:0] a);
        return pmem.exists(a >> 2) ? pmem[a >> 2] : 32'h0;
    endfunction

    function automatic logic [31:0] mk_entry(logic [19:0] frame, bit p, bit w, bit u, bit a, bit d);
        logic [31:0] e;
        e = {frame, 12'($urandom)};
        e[0] = p; e[1] = w; e[2] = u; e[5] = a; e[6] = d;
        return e;
    endfunction

    function automatic bit denied(logic [31:0] e, bit wr, bit usr);
        return !e[0] || (wr && !e[1]) || (usr && !e[2]);
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // memory model: handshakes resolved at the falling edge before the rising edge they occur on
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rd_pend) begin
                if (rd_lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = rd_data;
                    rd_pend = 1'b0;
                end else begin
                    rd_lat--;
                end
            end
            mem_req_ready = ($urandom_range(0, 3) != 0);
            if (rst_n && mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    pmem[mem_req_addr >> 2] = mem_req_wdata;
                    n_wr++;
                end else begin
                    if (n_rd < 4) rd_log[n_rd] = mem_req_addr;
                    n_rd++;
                    rd_data = rd_word(mem_req_addr);
                    rd_pend = 1'b1;
                    rd_lat  = $urandom_range(0, 2);
                end
            end
        end
    end

    task automatic run_txn(input logic [31:0] va, input bit wr, input bit usr,
                           input logic [19:0] root, input logic [31:0] pde, input logic [31:0] pte);
        logic [31:0] pde_a, pte_a, e_pde, e_pte, e_pa;
        bit          e_flt;
        int          e_rd, e_wr;
        string       tag;
        pde_a = {root, 12'h0} | (32'(va[31:22]) << 2);
        pte_a = {pde[31:12], 12'h0} | (32'(va[21:12]) << 2);
        pmem.delete();
        pmem[pde_a >> 2] = pde;
        pmem[pte_a >> 2] = pte;
        // expected outcome from the requirements
        e_pde = pde; e_pte = pte; e_pa = '0; e_wr = 0;
        if (denied(pde, wr, usr)) begin
            e_flt = 1'b1; e_rd = 1;
            tag = !pde[0] ? "R4" : (wr && !pde[1]) ? "R6" : "R7";
        end else begin
            e_rd  = 2;
            e_pde = pde | 32'h20;
            if (e_pde != pde) e_wr++;
            if (denied(pte, wr, usr)) begin
                e_flt = 1'b1;
                tag = !pte[0] ? "R5" : (wr && !pte[1]) ? "R6" : "R7";
            end else begin
                e_flt = 1'b0;
                tag   = "R3";
                e_pte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (e_pte != pte) e_wr++;
                e_pa = {pte[31:12], va[11:0]};
            end
        end
        if (e_flt) exp_fva = va;

        @(negedge clk);
        n_rd = 0; n_wr = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; root_frame = root;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = $urandom; root_frame = 20'($urandom);
        while (!rsp_valid) @(negedge clk);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rsp_ready = 1'b1;
        chk(tag, "fault flag", 32'(rsp_fault), 32'(e_flt));
        if (!e_flt) chk("R3", "physical address", rsp_paddr, e_pa);
        chk("R11", "req_ready during response", 32'(req_ready), 32'h0);
        chk("R2", "directory entry address", rd_log[0], pde_a);
        if (e_rd == 2) chk("R2", "table entry address", rd_log[1], pte_a);
        chk("R4", "read count", 32'(n_rd), 32'(e_rd));
        chk("R9", "write count", 32'(n_wr), 32'(e_wr));
        chk("R8", "directory entry in memory", rd_word(pde_a), e_pde);
        chk("R10", "table entry in memory", rd_word(pte_a), e_pte);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R10", "fault address", fault_vaddr, exp_fva);
        chk("R12", "no traffic after response", 32'(n_rd + n_wr), 32'(e_rd + e_wr));
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready", 32'(req_ready), 32'h1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'h0);
        chk("R1", "fault_vaddr", fault_vaddr, 32'h0);

        // directed corners
        // R4: absent directory entry
        run_txn(32'hF108_4150, 1'b0, 1'b0, 20'h00010, mk_entry(20'h00021, 0, 1, 1, 0, 0), mk_entry(20'h12345, 1, 1, 1, 0, 0));
        // R5: absent leaf entry
        run_txn(32'h0040_2ABC, 1'b0, 1'b0, 20'h00030, mk_entry(20'h00022, 1, 1, 1, 1, 0), mk_entry(20'h54321, 0, 1, 1, 0, 0));
        // R6: write through read-only directory, kernel mode
        run_txn(32'h8000_1004, 1'b1, 1'b0, 20'h00010, mk_entry(20'h00023, 1, 0, 1, 0, 0), mk_entry(20'h0ABCD, 1, 1, 1, 0, 0));
        // R7: user access to kernel leaf
        run_txn(32'h1234_5678, 1'b0, 1'b1, 20'h00030, mk_entry(20'h00024, 1, 1, 1, 0, 0), mk_entry(20'h0BEEF, 1, 1, 0, 0, 0));
        // R7: kernel access ignores user bit
        run_txn(32'h1234_5678, 1'b0, 1'b0, 20'h00030, mk_entry(20'h00024, 1, 1, 0, 0, 0), mk_entry(20'h0BEEF, 1, 1, 0, 0, 0));
        // R9: all flags already set, no write-back
        run_txn(32'hFFFF_FFFF, 1'b1, 1'b1, 20'h00010, mk_entry(20'h0002F, 1, 1, 1, 1, 1), mk_entry(20'hFFFFF, 1, 1, 1, 1, 1));
        // R8: write with accessed set, dirty clear: one leaf write-back
        run_txn(32'h0000_0000, 1'b1, 1'b0, 20'h00010, mk_entry(20'h00020, 1, 1, 1, 1, 1), mk_entry(20'h00000, 1, 1, 1, 1, 0));
        // R10: leaf write fault still marks directory accessed
        run_txn(32'h7FC0_0FFF, 1'b1, 1'b1, 20'h00030, mk_entry(20'h00025, 1, 1, 1, 0, 0), mk_entry(20'h33333, 1, 0, 1, 0, 0));

        // constrained random walks
        for (int i = 0; i < 300; i++) begin
            logic [19:0] root;
            root = ($urandom_range(0, 1) != 0) ? 20'h00010 : 20'h00030;
            run_txn($urandom, $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, root,
                    mk_entry(20'h00020 + 20'($urandom_range(0, 15)), $urandom_range(0, 7) != 0,
                             $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                             $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0),
                    mk_entry(20'($urandom), $urandom_range(0, 7) != 0,
                             $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                             $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule